// File: doc/BRIEF.md
# Pipelined Dadda Tree Multiplier

This block is an unsigned integer multiplier for two operands of equal width (8 bits by default) that yields the full double-width product. It is fully pipelined. A new operand pair can enter on every clock cycle, and each result leaves a fixed seven cycles later, paired with an output valid flag. No stall or backpressure path exists, so the consumer must take each result on the cycle it appears.

Internally, AND gates form every partial-product bit. A Dadda counter tree, built from full and half adders only, then squeezes those bits to two rows. For the 8-bit default it does this through the row-height limits 6, 4, 3 and 2. The first three pipeline cycles hold this reduction. A carry-lookahead adder spread over four further register stages adds the two rows. It uses 4-bit group generate and propagate logic, with a second lookahead level across the groups. A valid bit travels beside the data through all seven stages.

Top module: `dadda_mul`

## Requirements
- R1: `product` equals the unsigned product `op_a * op_b` of the pair presented with `in_valid` high, given in all 2*W bits with no truncation.
- R2: `out_valid` rises on the seventh rising clock edge after the edge that samples `in_valid` high (edge E samples, result visible after edge E+6), and `product` carries that pair's result in that same cycle.
- R3: A new pair can be presented on every cycle. Pairs sent on consecutive cycles return on consecutive cycles, in issue order, each with its own correct product.
- R4: A cycle with `in_valid` low yields a cycle with `out_valid` low seven edges later, whatever the operand values were. The number of results equals the number of valid inputs.
- R5: While `rst_n` is low, `out_valid` is low. Pairs in flight when reset is asserted never produce an output.
- R6: The extreme operands are exact: 255*255 gives 0xFE01, 255*254 gives 0xFD02, and any zero operand gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is to be multiplied |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| out_valid | output | 1 | `product` holds a result this cycle |
| product | output | 2*W | Unsigned product |

## Verification
The bench builds the block with its default width W=8, with four-bit lookahead groups. At that width all 65,536 operand pairs can be pushed through back to back in one sweep, so every column height and carry path of the reduction tree is covered, not a sample of them. A short table of hand-computed corner products runs first. Directed runs then interleave bubbles carrying junk operands, and a reset that lands while results are still in flight.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

  // Ascending Dadda height limits: 2, 3, 4, 6, 9, 13, ...
  function automatic int dadda_seq(input int k);
    int d;
    d = 2;
    for (int t = 0; t < 32; t++)
      if (t < k) d = (d * 3) / 2;
    return d;
  endfunction

  // Number of reduction levels needed to bring height h down to two rows
  function automatic int dadda_levels(input int h);
    int n;
    n = 0;
    for (int t = 0; t < 32; t++)
      if (dadda_seq(t) < h) n = t + 1;
    return n;
  endfunction

  // Target height of reduction level j (level 0 is the first applied)
  function automatic int dadda_target(input int h, input int j);
    return dadda_seq(dadda_levels(h) - 1 - j);
  endfunction

  // Pipeline cycle that hosts reduction level j
  function automatic int level_cycle(input int j, input int nl, input int ncyc);
    int c;
    c = (ncyc * j + 1) / nl;
    return (c > ncyc - 1) ? ncyc - 1 : c;
  endfunction

endpackage

// File: rtl/dadda_level_stage.sv
module dadda_level_stage
  import dadda_pkg::*;
#(
  parameter int W    = 8,
  parameter int CYC  = 0,
  parameter int NCYC = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2*W-1:0][W-1:0]     mat_in,
  output logic                      out_valid,
  output logic [2*W-1:0][W-1:0]     mat_out
);
  localparam int NC = 2 * W;
  localparam int NL = dadda_levels(W);

  typedef logic [NC-1:0][W-1:0] mat_t;

  mat_t red_d;

  // Columns are kept left-justified; h[] tracks heights, which depend only
  // on parameters. Levels owned by earlier cycles update heights only.
  always_comb begin
    mat_t cur;
    mat_t nxt;
    int   h  [NC];
    int   nh [NC];
    int   p, r, d;
    cur = mat_in;
    for (int i = 0; i < NC; i++)
      h[i] = (i < NC - 1) ? ((i < W) ? i + 1 : NC - 1 - i) : 0;
    for (int j = 0; j < NL; j++) begin
      if (level_cycle(j, NL, NCYC) <= CYC) begin
        d   = dadda_target(W, j);
        nxt = '0;
        for (int i = 0; i < NC; i++) nh[i] = 0;
        for (int i = 0; i < NC; i++) begin
          p = 0;
          for (int k = 0; k < W; k++) begin
            r = h[i] - p;
            if ((r + nh[i] > d) && (r >= 2)) begin
              if ((r + nh[i] == d + 1) || (r < 3)) begin
                nxt[i][nh[i]] = cur[i][p] ^ cur[i][p+1];
                nh[i] = nh[i] + 1;
                if (i < NC - 1) begin
                  nxt[i+1][nh[i+1]] = cur[i][p] & cur[i][p+1];
                  nh[i+1] = nh[i+1] + 1;
                end
                p = p + 2;
              end else begin
                nxt[i][nh[i]] = cur[i][p] ^ cur[i][p+1] ^ cur[i][p+2];
                nh[i] = nh[i] + 1;
                if (i < NC - 1) begin
                  nxt[i+1][nh[i+1]] = (cur[i][p] & cur[i][p+1]) |
                                      (cur[i][p+2] & (cur[i][p] ^ cur[i][p+1]));
                  nh[i+1] = nh[i+1] + 1;
                end
                p = p + 3;
              end
            end
          end
          for (int k = 0; k < W; k++)
            if (k < h[i] - p) nxt[i][nh[i] + k] = cur[i][p + k];
          nh[i] = nh[i] + h[i] - p;
        end
        cur = (level_cycle(j, NL, NCYC) < CYC) ? mat_in : nxt;
        h   = nh;
      end
    end
    red_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) mat_out <= red_d;
  end

endmodule

// File: rtl/cla_pipe.sv
module cla_pipe #(
  parameter int N = 16,
  parameter int G = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic         out_valid,
  output logic [N-1:0] sum
);
  localparam int NG = N / G;

  logic [3:0]    v_q;
  logic [N-1:0]  g1_q, p1_q, g2_q, p2_q, g3_q, p3_q;
  logic [NG-1:0] gg_d, pg_d, gg2_q, pg2_q, cg_d, cg3_q;
  logic [N-1:0]  sum_d;

  // group generate / propagate from bit signals
  always_comb begin
    for (int k = 0; k < NG; k++) begin
      gg_d[k] = 1'b0;
      pg_d[k] = 1'b1;
      for (int b = 0; b < G; b++) begin
        gg_d[k] = g1_q[k*G+b] | (p1_q[k*G+b] & gg_d[k]);
        pg_d[k] = pg_d[k] & p1_q[k*G+b];
      end
    end
  end

  // second-level lookahead: carry into each group
  always_comb begin
    logic c;
    c = 1'b0;
    for (int k = 0; k < NG; k++) begin
      cg_d[k] = c;
      c = gg2_q[k] | (pg2_q[k] & c);
    end
  end

  // in-group carries and sum bits
  always_comb begin
    logic c;
    for (int k = 0; k < NG; k++) begin
      c = cg3_q[k];
      for (int b = 0; b < G; b++) begin
        sum_d[k*G+b] = p3_q[k*G+b] ^ c;
        c = g3_q[k*G+b] | (p3_q[k*G+b] & c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      g1_q <= x & y;
      p1_q <= x ^ y;
    end
    if (v_q[0]) begin
      g2_q  <= g1_q;
      p2_q  <= p1_q;
      gg2_q <= gg_d;
      pg2_q <= pg_d;
    end
    if (v_q[1]) begin
      g3_q  <= g2_q;
      p3_q  <= p2_q;
      cg3_q <= cg_d;
    end
    if (v_q[2]) sum <= sum_d;
  end

  assign out_valid = v_q[3];

endmodule

// File: rtl/dadda_mul.sv
module dadda_mul
  import dadda_pkg::*;
#(
  parameter int W     = 8,
  parameter int GROUP = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int NC      = 2 * W;
  localparam int RED_CYC = 3;

  typedef logic [NC-1:0][W-1:0] mat_t;

  mat_t             mats [RED_CYC+1];
  logic [RED_CYC:0] vals;
  logic [NC-1:0]    row_x, row_y;

  // partial products, left-justified in each column
  always_comb begin
    int lo;
    mats[0] = '0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++) begin
        lo = (i + j > W - 1) ? i + j - W + 1 : 0;
        mats[0][i+j][i-lo] = op_a[i] & op_b[j];
      end
  end

  assign vals[0] = in_valid;

  for (genvar c = 0; c < RED_CYC; c++) begin : g_red
    dadda_level_stage #(.W(W), .CYC(c), .NCYC(RED_CYC)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (vals[c]),
      .mat_in   (mats[c]),
      .out_valid(vals[c+1]),
      .mat_out  (mats[c+1])
    );
  end

  for (genvar i = 0; i < NC; i++) begin : g_rows
    assign row_x[i] = mats[RED_CYC][i][0];
    assign row_y[i] = mats[RED_CYC][i][1];
  end

  cla_pipe #(.N(NC), .G(GROUP)) u_cla (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (vals[RED_CYC]),
    .x        (row_x),
    .y        (row_y),
    .out_valid(out_valid),
    .sum      (product)
  );

endmodule

// File: rtl/dadda_mul_chk.sv
module dadda_mul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           out_valid,
  input logic [2*W-1:0] product
);
  logic [6:0]     v_sh;
  logic [2*W-1:0] p_sh [7];
  logic [6:0]     z_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_sh <= '0;
    else        v_sh <= {v_sh[5:0], in_valid};
  end

  always_ff @(posedge clk) begin
    p_sh[0] <= (2*W)'(op_a) * (2*W)'(op_b);
    z_sh    <= {z_sh[5:0], (op_a == '0) || (op_b == '0)};
    for (int i = 1; i < 7; i++) p_sh[i] <= p_sh[i-1];
  end

  AST_LATENCY_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_sh[6]);                                              // R2
  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product == p_sh[6]);                                  // R1
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (v_sh[6] && v_sh[5]) |=> out_valid && product == $past(p_sh[5]));   // R3
  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !v_sh[6] |-> !out_valid);                                           // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !out_valid);                                             // R5
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && z_sh[6]) |-> product == '0);                          // R6

endmodule

bind dadda_mul dadda_mul_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op_a     (op_a),
  .op_b     (op_b),
  .out_valid(out_valid),
  .product  (product)
);

// File: tb/dadda_mul_tb.sv
module dadda_mul_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // fields: {a[31:24], b[23:16], expected product[15:0]}
  localparam logic [31:0] VEC [NV] = '{
    32'h00_00_0000, 32'hFF_FF_FE01, 32'h01_FF_00FF, 32'hFF_01_00FF,
    32'h00_C8_0000, 32'h80_80_4000, 32'h0F_11_00FF, 32'hAA_55_3872,
    32'hC8_03_0258, 32'h63_65_270F, 32'hFE_FF_FD02, 32'h10_10_0100
  };

  logic        clk, rst_n, in_valid;
  logic [7:0]  op_a, op_b;
  logic        out_valid;
  logic [15:0] product;

  int unsigned cyc = 0;
  int          total = 0, bad = 0, seen = 0, stray = 0;
  bit          done = 0;
  int unsigned q_due [$];
  logic [15:0] q_exp [$];
  string       q_tag [$];

  dadda_mul u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, samples at the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      seen++;
      if (q_due.size() == 0) begin
        bad++;
        stray++;
        $display("FAIL R4/R5 unexpected out_valid at cycle %0d: actual product=%h expected no output",
                 cyc, product);
      end else begin
        if (product !== q_exp[0] || cyc != q_due[0]) begin
          bad++;
          $display("FAIL %s product=%h cycle=%0d expected product=%h cycle=%0d",
                   q_tag[0], product, cyc, q_exp[0], q_due[0]);
        end
        void'(q_due.pop_front());
        void'(q_exp.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  task automatic issue(input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] e, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    q_due.push_back(cyc + 1 + 6);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input logic [7:0] junk);
    @(negedge clk);
    in_valid = 1'b0;
    op_a = junk;
    op_b = ~junk;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int issued;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5 out_valid during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(out_valid == 1'b0 && seen == 0, "R5 idle after reset", seen, 0);

    // table of corner products, back to back (R3, R6)
    for (int i = 0; i < NV; i++)
      issue(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], "R6 table");
    idle(8'h5A);
    repeat (10) @(negedge clk);
    check(seen == NV, "R3 table results returned", seen, NV);

    // bubbles with junk operands (R4)
    issued = seen;
    for (int i = 0; i < 20; i++) begin
      issue(8'(i * 13 + 7), 8'(255 - i * 9), 16'((i * 13 + 7) * (255 - i * 9)), "R4 bubble");
      idle(8'(i * 31));
      idle(8'hFF);
    end
    repeat (10) @(negedge clk);
    check(seen - issued == 20, "R4 one result per valid input", seen - issued, 20);
    check(q_due.size() == 0, "R4 queue drained", q_due.size(), 0);

    // reset while results are in flight (R5)
    for (int i = 0; i < 4; i++) issue(8'(i + 100), 8'(i + 3), 16'((i + 100) * (i + 3)), "R5 flight");
    idle(8'h00);
    rst_n = 1'b0;
    q_due.delete(); q_exp.delete(); q_tag.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R5 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    issued = seen;
    repeat (12) @(negedge clk);
    check(seen == issued && stray == 0, "R5 in-flight pairs dropped", seen - issued, 0);

    // exhaustive sweep, back to back (R1, R2, R3)
    issued = seen;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        issue(8'(a), 8'(b), 16'(a * b), "R1 sweep");
    idle(8'h00);
    repeat (10) @(negedge clk);
    check(seen - issued == 65536, "R2 sweep result count", seen - issued, 65536);
    check(q_due.size() == 0 && stray == 0, "R3 sweep drained in order", q_due.size(), 0);
    finish_run();
  end

endmodule